// File: doc/BRIEF.md
# J1850 Receive Status Controller

This block handles the receive side of a byte-oriented J1850 data link controller. A symbol decoder upstream sends it one-cycle event pulses: start-of-frame, byte received (with the byte value), end-of-data, end-of-frame and invalid symbol. From these events the block keeps a received-data register and a set of pending receive conditions. It reports the most urgent condition as a 4-bit state code. It also checks a CRC-8 over each frame segment and raises an interrupt request to the CPU.

The CPU reads the received byte through a read strobe, which also acknowledges it. It reads the state code directly from an output. When a message is of no interest, the CPU can set an ignore bit. While that bit is set, bus activity does not change the status and no interrupt is raised. The next start-of-frame, or a CPU clear, releases it. This means software only has to handle messages it has chosen to keep.

Top module: `j1850_rx_status`

## Requirements
- R1: After reset, the data register is 0x00, no condition is pending, the state code is 0, the interrupt request is low and the ignore bit is clear.
- R2: A byte event while the ignore bit is clear loads the byte into the data register and sets the data-full condition (code 2). This applies to every byte, including CRC bytes.
- R3: A data read strobe clears the data-full and overrun conditions, unless a byte event in the same cycle sets data-full again.
- R4: A byte event that arrives while data-full is pending, with no read in the same cycle, sets the overrun condition (code 3), and the new byte replaces the data register.
- R5: An end-of-frame event sets the frame-complete condition (code 1). A start-of-frame event clears frame-complete, CRC-error and invalid-symbol.
- R6: The CRC is x^8+x^4+x^3+x^2+1 (0x1D), processed MSB first, starting from 0xFF. It restarts at start-of-frame and at every end-of-data. At end-of-data, a running value other than 0xC4 sets the CRC-error condition (code 4). The response segment after the first end-of-data is therefore checked on its own.
- R7: An invalid-symbol event sets the invalid-symbol condition (code 5).
- R8: The state code shows the highest pending condition, in this order: invalid symbol (5), CRC error (4), overrun (3), data-full (2), frame-complete (1). It shows none (0) when nothing is pending. Showing the code clears nothing.
- R9: The CPU sets the ignore bit by strobe and clears it by strobe, and clear wins over set. Start-of-frame clears the bit. While the bit is set, no bus event other than start-of-frame changes the data register or any condition.
- R10: The interrupt request is high exactly when some condition is pending, the interrupt enable is high and the ignore bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame event pulse |
| byte_vld_i | input | 1 | Byte received event pulse |
| byte_i | input | 8 | Received byte value |
| eod_i | input | 1 | End-of-data event pulse |
| eof_i | input | 1 | End-of-frame event pulse |
| bad_sym_i | input | 1 | Invalid or out-of-range symbol event pulse |
| rd_data_i | input | 1 | CPU read strobe for the data register |
| ign_set_i | input | 1 | CPU strobe that sets the ignore bit |
| ign_clr_i | input | 1 | CPU strobe that clears the ignore bit |
| irq_en_i | input | 1 | Interrupt enable |
| data_o | output | 8 | Received-data register |
| vec_o | output | 4 | State code of the highest pending condition |
| ign_o | output | 1 | Ignore bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the decoder raises at most one bus event per cycle and that each event lasts a single cycle. This matters most for start-of-frame and end-of-data, which reset the CRC register, and for byte events, which feed it. The stimulus drives whole frames one event per cycle, in order: start, payload, CRC byte, end-of-data, an optional response segment, then end-of-frame. Invalid symbols are inserted only in otherwise idle cycles. CPU strobes are drawn freely alongside any event, so read/byte collisions and set/clear collisions do occur.

// File: rtl/j1850_rx_pkg.sv
package j1850_rx_pkg;

  typedef enum logic [3:0] {
    VEC_NONE = 4'h0,
    VEC_EOF  = 4'h1,
    VEC_RDF  = 4'h2,
    VEC_OVR  = 4'h3,
    VEC_CRC  = 4'h4,
    VEC_BAD  = 4'h5
  } vec_e;

  typedef struct packed {
    logic bad;
    logic crc;
    logic ovr;
    logic rdf;
    logic eof;
  } cond_t;

  function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in,
                                           input logic [7:0] data,
                                           input logic [7:0] poly);
    logic [7:0] c;
    c = crc_in;
    for (int i = 7; i >= 0; i--) begin
      if (c[7] ^ data[i]) c = {c[6:0], 1'b0} ^ poly;
      else                c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/j1850_rx_crc.sv
module j1850_rx_crc
  import j1850_rx_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  POLY    = 8'h1D,
  parameter logic [7:0]  INIT    = 8'hFF,
  parameter logic [7:0]  RESIDUE = 8'hC4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              eod_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              crc_bad_o
);

  logic [7:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                crc_q <= INIT;
    else if (sof_i || eod_i)    crc_q <= INIT;  // new frame or response segment
    else if (byte_vld_i)        crc_q <= crc8_byte(crc_q, byte_i[7:0], POLY);
  end

  assign crc_bad_o = eod_i && (crc_q != RESIDUE);

  p_crc_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i || eod_i) |=> (crc_q == INIT));

endmodule

// File: rtl/j1850_rx_cond.sv
module j1850_rx_cond
  import j1850_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              eof_i,
  input  logic              bad_sym_i,
  input  logic              crc_bad_i,
  input  logic              rd_data_i,
  input  logic              ign_set_i,
  input  logic              ign_clr_i,
  output logic [DATA_W-1:0] data_o,
  output cond_t             cond_o,
  output logic              ign_o
);

  logic [DATA_W-1:0] data_q;
  cond_t             cond_q, cond_d;
  logic              ign_q;
  logic              live;
  logic              take_byte;

  assign live      = !ign_q;
  assign take_byte = live && byte_vld_i;

  always_comb begin
    cond_d = cond_q;
    if (take_byte) begin
      cond_d.ovr = !rd_data_i && (cond_q.ovr || cond_q.rdf);
      cond_d.rdf = 1'b1;
    end else if (rd_data_i) begin
      cond_d.ovr = 1'b0;
      cond_d.rdf = 1'b0;
    end
    if (sof_i) begin
      cond_d.eof = 1'b0;
      cond_d.crc = 1'b0;
      cond_d.bad = 1'b0;
    end else if (live) begin
      if (eof_i)     cond_d.eof = 1'b1;
      if (crc_bad_i) cond_d.crc = 1'b1;
      if (bad_sym_i) cond_d.bad = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cond_q <= '0;
      ign_q  <= 1'b0;
    end else begin
      cond_q <= cond_d;
      if (take_byte) data_q <= byte_i;
      if (sof_i || ign_clr_i) ign_q <= 1'b0;
      else if (ign_set_i)     ign_q <= 1'b1;
    end
  end

  assign data_o = data_q;
  assign cond_o = cond_q;
  assign ign_o  = ign_q;

  p_ign_holds_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ign_q && !sof_i) |=> $stable(data_q));
  p_ign_holds_eof_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ign_q && !sof_i) |=> !$rose(cond_q.eof) && !$rose(cond_q.bad) && !$rose(cond_q.crc));
  p_sof_clears_ign_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> !ign_q);
  p_rd_clears_rdf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !byte_vld_i) |=> (!cond_q.rdf && !cond_q.ovr));
  p_ovr_needs_rdf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_q.ovr |-> cond_q.rdf);

endmodule

// File: rtl/j1850_rx_vec.sv
module j1850_rx_vec
  import j1850_rx_pkg::*;
(
  input  cond_t      cond_i,
  output logic [3:0] vec_o
);

  vec_e vec;

  always_comb begin
    if      (cond_i.bad) vec = VEC_BAD;
    else if (cond_i.crc) vec = VEC_CRC;
    else if (cond_i.ovr) vec = VEC_OVR;
    else if (cond_i.rdf) vec = VEC_RDF;
    else if (cond_i.eof) vec = VEC_EOF;
    else                 vec = VEC_NONE;
  end

  assign vec_o = vec;

endmodule

// File: rtl/j1850_rx_status.sv
module j1850_rx_status
  import j1850_rx_pkg::*;
#(
  parameter int         DATA_W  = 8,
  parameter logic [7:0] POLY    = 8'h1D,
  parameter logic [7:0] INIT    = 8'hFF,
  parameter logic [7:0] RESIDUE = 8'hC4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              eod_i,
  input  logic              eof_i,
  input  logic              bad_sym_i,
  input  logic              rd_data_i,
  input  logic              ign_set_i,
  input  logic              ign_clr_i,
  input  logic              irq_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic [3:0]        vec_o,
  output logic              ign_o,
  output logic              irq_o
);

  cond_t cond;
  logic  crc_bad;

  j1850_rx_crc #(
    .DATA_W(DATA_W), .POLY(POLY), .INIT(INIT), .RESIDUE(RESIDUE)
  ) u_crc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sof_i      (sof_i),
    .eod_i      (eod_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .crc_bad_o  (crc_bad)
  );

  j1850_rx_cond #(.DATA_W(DATA_W)) u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sof_i      (sof_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .eof_i      (eof_i),
    .bad_sym_i  (bad_sym_i),
    .crc_bad_i  (crc_bad),
    .rd_data_i  (rd_data_i),
    .ign_set_i  (ign_set_i),
    .ign_clr_i  (ign_clr_i),
    .data_o     (data_o),
    .cond_o     (cond),
    .ign_o      (ign_o)
  );

  j1850_rx_vec u_vec (
    .cond_i (cond),
    .vec_o  (vec_o)
  );

  assign irq_o = irq_en_i && !ign_o && (|cond);

  p_irq_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ign_o || !irq_en_i) |-> !irq_o);
  p_irq_on_vec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && !ign_o && vec_o != 4'h0) |-> irq_o);
  p_bad_on_top_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond.bad |-> (vec_o == 4'h5));
  p_idle_vec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond == '0) |-> (vec_o == 4'h0));

endmodule

// File: tb/j1850_rx_status_test.sv
module j1850_rx_status_test;

  localparam int CLK_PERIOD = 10;
  localparam int EV_IDLE = 0, EV_SOF = 1, EV_BYTE = 2, EV_EOD = 3, EV_EOF = 4, EV_BAD = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 0, byte_vld = 0, eod = 0, eof = 0, bad = 0;
  logic [7:0] byte_v = 8'h00;
  logic       rd = 0, iset = 0, iclr = 0, irq_en = 0;
  logic [7:0] data;
  logic [3:0] vec;
  logic       ign, irq;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  logic [7:0] m_data, m_crc;
  logic       m_rdf, m_ovr, m_eof, m_crce, m_bad, m_ign;

  always #(CLK_PERIOD/2) clk = ~clk;

  j1850_rx_status uut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .byte_vld_i(byte_vld), .byte_i(byte_v),
    .eod_i(eod), .eof_i(eof), .bad_sym_i(bad), .rd_data_i(rd), .ign_set_i(iset),
    .ign_clr_i(iclr), .irq_en_i(irq_en), .data_o(data), .vec_o(vec), .ign_o(ign), .irq_o(irq)
  );

  function automatic logic [7:0] tb_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb;
      fb = r[7] ^ d[7-k];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h1D;
    end
    return r;
  endfunction

  function automatic logic [3:0] exp_vec();
    if (m_bad)  return 4'h5;
    if (m_crce) return 4'h4;
    if (m_ovr)  return 4'h3;
    if (m_rdf)  return 4'h2;
    if (m_eof)  return 4'h1;
    return 4'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2 data", 32'(data), 32'(m_data));
    chk("R8 vec", 32'(vec), 32'(exp_vec()));
    chk("R9 ign", 32'(ign), 32'(m_ign));
    chk("R10 irq", 32'(irq), 32'(irq_en && !m_ign && (m_bad|m_crce|m_ovr|m_rdf|m_eof)));
  endtask

  task automatic model_reset();
    m_data = 8'h00; m_crc = 8'hFF;
    m_rdf = 0; m_ovr = 0; m_eof = 0; m_crce = 0; m_bad = 0; m_ign = 0;
  endtask

  task automatic model_step(input int ev, input logic [7:0] b, input logic r,
                            input logic s, input logic c);
    logic live;
    live = !m_ign;
    if (ev == EV_BYTE && live) begin
      m_data = b;
      m_ovr  = !r && (m_ovr || m_rdf);
      m_rdf  = 1'b1;
    end else if (r) begin
      m_rdf = 0; m_ovr = 0;
    end
    if (ev == EV_SOF) begin
      m_eof = 0; m_crce = 0; m_bad = 0;
    end else if (live) begin
      if (ev == EV_EOF) m_eof = 1;
      if (ev == EV_BAD) m_bad = 1;
      if (ev == EV_EOD && m_crc != 8'hC4) m_crce = 1;
    end
    if (ev == EV_SOF || ev == EV_EOD) m_crc = 8'hFF;
    else if (ev == EV_BYTE) m_crc = tb_crc(m_crc, b);
    if (ev == EV_SOF || c) m_ign = 0;
    else if (s) m_ign = 1;
  endtask

  task automatic step(input int ev, input logic [7:0] b, input logic r,
                      input logic s, input logic c);
    @(negedge clk);
    sof = (ev == EV_SOF); byte_vld = (ev == EV_BYTE); eod = (ev == EV_EOD);
    eof = (ev == EV_EOF); bad = (ev == EV_BAD); byte_v = b;
    rd = r; iset = s; iclr = c;
    model_step(ev, b, r, s, c);
    @(negedge clk);
    sof = 0; byte_vld = 0; eod = 0; eof = 0; bad = 0; rd = 0; iset = 0; iclr = 0;
    compare();
  endtask

  // sends a segment with correct or corrupted CRC, reading each byte
  task automatic segment(input int n, input logic corrupt);
    logic [7:0] c, b;
    c = 8'hFF;
    for (int k = 0; k < n; k++) begin
      b = 8'($urandom);
      c = tb_crc(c, b);
      step(EV_BYTE, b, 1'b0, 1'b0, 1'b0);
      step(EV_IDLE, 8'h00, 1'b1, 1'b0, 1'b0);
    end
    b = ~c;
    if (corrupt) b = b ^ 8'h01;
    step(EV_BYTE, b, 1'b0, 1'b0, 1'b0);
    step(EV_IDLE, 8'h00, 1'b1, 1'b0, 1'b0);
    step(EV_EOD, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1850));
    model_reset();
    irq_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 data", 32'(data), 0);
    chk("R1 vec", 32'(vec), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 ign", 32'(ign), 0);
    rst_n = 1'b1;

    // R2/R3/R4
    step(EV_SOF, 8'h00, 0, 0, 0);
    step(EV_BYTE, 8'hA5, 0, 0, 0);
    chk("R2 data", 32'(data), 32'hA5);
    chk("R2 vec", 32'(vec), 2);
    chk("R10 irq", 32'(irq), 1);
    step(EV_IDLE, 8'h00, 1, 0, 0);
    chk("R3 vec after read", 32'(vec), 0);
    step(EV_BYTE, 8'h11, 0, 0, 0);
    step(EV_BYTE, 8'h22, 0, 0, 0);
    chk("R4 vec", 32'(vec), 3);
    chk("R4 data", 32'(data), 32'h22);
    step(EV_BYTE, 8'h33, 1, 0, 0);
    chk("R3 byte with read", 32'(vec), 2);
    step(EV_IDLE, 8'h00, 1, 0, 0);
    chk("R3 clear", 32'(vec), 0);

    // R6 good frame with response segment, then R5
    step(EV_SOF, 8'h00, 0, 0, 0);
    segment(3, 1'b0);
    chk("R6 good crc", 32'(vec), 0);
    segment(1, 1'b0);
    chk("R6 response crc", 32'(vec), 0);
    step(EV_EOF, 8'h00, 0, 0, 0);
    chk("R5 eof", 32'(vec), 1);
    step(EV_SOF, 8'h00, 0, 0, 0);
    chk("R5 sof clears", 32'(vec), 0);
    segment(2, 1'b1);
    chk("R6 bad crc", 32'(vec), 4);
    step(EV_EOF, 8'h00, 0, 0, 0);
    chk("R8 crc over eof", 32'(vec), 4);
    step(EV_BAD, 8'h00, 0, 0, 0);
    chk("R7 bad symbol", 32'(vec), 5);
    step(EV_SOF, 8'h00, 0, 0, 0);
    chk("R5 sof clears bad", 32'(vec), 0);

    // R9 ignore
    step(EV_BYTE, 8'h5A, 0, 1, 0);
    chk("R9 ign set", 32'(ign), 1);
    chk("R10 irq masked", 32'(irq), 0);
    step(EV_BYTE, 8'hC3, 0, 0, 0);
    chk("R9 data held", 32'(data), 32'h5A);
    step(EV_EOF, 8'h00, 0, 0, 0);
    step(EV_BAD, 8'h00, 0, 0, 0);
    chk("R9 vec held", 32'(vec), 2);
    step(EV_IDLE, 8'h00, 0, 1, 1);
    chk("R9 clr wins", 32'(ign), 0);
    step(EV_IDLE, 8'h00, 0, 1, 0);
    step(EV_SOF, 8'h00, 0, 0, 0);
    chk("R9 sof releases", 32'(ign), 0);
    step(EV_IDLE, 8'h00, 1, 0, 0);

    // random frames
    for (int f = 0; f < 400; f++) begin
      int nb;
      logic [7:0] c;
      irq_en = ($urandom % 4) != 0;
      step(EV_SOF, 8'h00, ($urandom % 2) == 0, 1'b0, 1'b0);
      for (int seg = 0; seg < 2; seg++) begin
        nb = 1 + ($urandom % 4);
        c = 8'hFF;
        for (int k = 0; k <= nb; k++) begin
          logic [7:0] b;
          if (k < nb) begin
            b = 8'($urandom);
            c = tb_crc(c, b);
          end else begin
            b = ~c;
            if (($urandom % 6) == 0) b = b ^ 8'($urandom % 255 + 1);
          end
          step(EV_BYTE, b, ($urandom % 10) < 6, ($urandom % 12) == 0, ($urandom % 20) == 0);
          if (($urandom % 3) == 0)
            step((($urandom % 15) == 0) ? EV_BAD : EV_IDLE, 8'h00, ($urandom % 2) == 0,
                 1'b0, ($urandom % 10) == 0);
        end
        step(EV_EOD, 8'h00, ($urandom % 2) == 0, 1'b0, 1'b0);
        if (($urandom % 2) == 0) break;
      end
      step(EV_EOF, 8'h00, ($urandom % 2) == 0, 1'b0, 1'b0);
      step(EV_IDLE, 8'h00, 1'b1, 1'b0, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule